// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single clause-22 management transactions on a two-wire MDIO bus. A host places a PHY address, a register number, a direction flag and, for writes, a 16-bit data word on the request inputs and pulses `start`. The block then generates the management clock and sends the complete frame. A frame has three parts: a preamble of ones, a 16-bit header word, and a 16-bit data field. In a write the block drives the data field. In a read the PHY drives it and the block shifts it in.

MDC comes from the system clock through a divider. Its half period is set in system clock cycles by a parameter. The MDIO line is split into an output value, an output-enable and a returned input, so that the pad tri-state is built outside the block. `busy` stays high for the whole frame. A one-cycle `done` marks the end of the frame, and for a read `rdata` holds the captured word from that cycle onward.

Top module: `mdio_master`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `done`, `mdc` and `mdio_oe` are all low, and `rdata` is zero.
- R2: While busy, MDC is low for MDC_HALF system cycles and then high for MDC_HALF cycles, so each bit slot lasts 2*MDC_HALF cycles. When idle, MDC stays low. The default MDC_HALF of 10 gives 2.5 MHz from a 50 MHz clock.
- R3: Slots 0 to 31 of a frame are the preamble: `mdio_oe` is high and `mdio_o` is 1.
- R4: Slots 32 to 47 carry the header MSB first. Header bits 15:14 are 01. Bits 13:12 are the opcode, 10 for read and 01 for write. Bits 11:7 are the PHY address, bits 6:2 are the register number, and bits 1:0 are 10.
- R5: A new bit appears on `mdio_o` only at the start of a slot, while MDC is low. It stays stable while MDC is high.
- R6: In a write, slots 48 to 63 carry `wdata` MSB first, and `mdio_oe` stays high through slot 63.
- R7: In a read, `mdio_oe` drops at the start of slot 48 and stays low. `mdio_i` is sampled in the last cycle of the high phase of each of slots 48 to 63, MSB first.
- R8: `done` is high for exactly one cycle, 128*MDC_HALF cycles after the edge that accepted `start`. `busy` falls in that same cycle. After a read, `rdata` shows the captured word from that cycle until the next read completes.
- R9: A `start` pulse while `busy` is high is ignored, and the frame in progress does not change.
- R10: `start` while not busy is accepted, and `busy` is high from the next cycle. This includes the `done` cycle, which allows back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| is_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register number |
| wdata | input | 16 | Write data |
| mdio_i | input | 1 | Value seen on the MDIO pin |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The bench tries writes with several data patterns to tell apart bit order and field placement in the header and data: alternating bits, all ones, and a sparse word. It also tries reads where the PHY returns 0xA5C3 and 0x8001, which separate a correct MSB-first capture from one that is reversed or shifted by one slot. One frame receives a stray `start` with every request field inverted, which shows whether a busy request is really ignored. Frames are also started in the `done` cycle, which checks that back-to-back requests are accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 16;
    localparam int DAT_BITS   = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + DAT_BITS;
    localparam int SHIFT_BITS = HDR_BITS + DAT_BITS;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_DATA
    } mdio_state_e;

    typedef struct packed {
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_req_t;

    function automatic logic [HDR_BITS-1:0] mdio_header(input mdio_req_t r);
        mdio_op_e op;
        op = r.is_read ? OP_READ : OP_WRITE;
        return {2'b01, op, r.phy, r.regn, 2'b10};
    endfunction

    function automatic logic [SHIFT_BITS-1:0] mdio_payload(input mdio_req_t r);
        return {mdio_header(r), (r.is_read ? {DAT_BITS{1'b0}} : r.wdata)};
    endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt;
    logic          last;

    assign last     = (cnt == CW'(HALF - 1));
    assign slot_end = run && last && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (last) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_tx_shifter.sv
module mdio_tx_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh;

    assign msb = sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_val;
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdio_rx_shifter.sv
module mdio_rx_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         commit,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            word <= '0;
        end else begin
            if (shift) sh <= {sh[W-2:0], din};
            if (commit) word <= {sh[W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int IDXW = $clog2(FRAME_BITS);

    mdio_state_e     state;
    logic [IDXW-1:0] bit_idx;
    logic [IDXW-1:0] nxt_idx;
    logic            rd_q;
    logic            slot_end;
    logic            accept;
    logic            last_slot;
    logic            tx_msb;
    logic            tx_shift;
    logic            rx_shift;
    logic            rx_commit;
    mdio_req_t       req_in;

    assign busy      = (state != ST_IDLE);
    assign accept    = start && !busy;
    assign nxt_idx   = bit_idx + 1'b1;
    assign last_slot = slot_end && (bit_idx == IDXW'(FRAME_BITS - 1));
    assign tx_shift  = slot_end && !last_slot && (nxt_idx >= IDXW'(PRE_BITS));
    assign rx_shift  = slot_end && rd_q && (state == ST_DATA);
    assign rx_commit = last_slot && rd_q;

    always_comb begin
        req_in.is_read = is_read;
        req_in.phy     = phy_addr;
        req_in.regn    = reg_addr;
        req_in.wdata   = wdata;
    end

    mdio_mdc_timer #(.HALF(MDC_HALF)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_tx_shifter #(.W(SHIFT_BITS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (mdio_payload(req_in)),
        .shift    (tx_shift),
        .msb      (tx_msb)
    );

    mdio_rx_shifter #(.W(DAT_BITS)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .shift  (rx_shift),
        .commit (rx_commit),
        .din    (mdio_i),
        .word   (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            rd_q    <= 1'b0;
            done    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= ST_PRE;
                bit_idx <= '0;
                rd_q    <= is_read;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (last_slot) begin
                state   <= ST_IDLE;
                done    <= 1'b1;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
            end else if (slot_end) begin
                bit_idx <= nxt_idx;
                mdio_o  <= (nxt_idx < IDXW'(PRE_BITS)) ? 1'b1 : tx_msb;
                if (nxt_idx == IDXW'(PRE_BITS)) begin
                    state <= ST_HDR;
                end
                if (nxt_idx == IDXW'(PRE_BITS + HDR_BITS)) begin
                    state   <= ST_DATA;
                    mdio_oe <= !rd_q;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mdc && !mdio_oe));

    assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    assert_bit_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    assert_oe_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 10;
    localparam int SLOT = 2 * HALF;
    localparam int FRAME_CYC = 64 * SLOT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic [15:0] phy_val = '0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // behavioural reference state
    bit          m_busy = 0;
    bit          m_done = 0;
    bit          m_read = 0;
    int          m_c = 0;
    logic [63:0] m_bits = '0;
    logic [15:0] m_sh = '0;
    logic [15:0] m_rdata = '0;

    always #5 clk = ~clk;

    mdio_master #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .start(start), .is_read(is_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .mdio_i(mdio_i), .busy(busy), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // reference model, advanced once per rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_c = 0; m_sh = '0; m_rdata = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_read && (m_c % SLOT) == SLOT - 1 && (m_c / SLOT) >= 48)
                    m_sh = {m_sh[14:0], mdio_i};
                if (m_c == FRAME_CYC - 1) begin
                    m_busy = 0;
                    m_done = 1;
                    if (m_read) m_rdata = m_sh;
                end else begin
                    m_c++;
                end
            end else if (start) begin
                m_busy = 1;
                m_c = 0;
                m_read = is_read;
                m_bits = {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01),
                          phy_addr, reg_addr, 2'b10, (is_read ? 16'h0 : wdata)};
            end
        end
    end

    // PHY side: drives its data during the data slots of a read
    always @(negedge clk) begin
        int j;
        j = m_c / SLOT;
        mdio_i <= (m_busy && m_read && j >= 48) ? phy_val[63 - j] : 1'b1;
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        int  j;
        bit  e_mdc, e_oe, e_mdo;
        string tag;
        vectors++;
        j     = m_c / SLOT;
        e_mdc = m_busy && ((m_c % SLOT) >= HALF);
        e_oe  = m_busy && (!m_read || j < 48);
        e_mdo = m_bits[63 - j];
        tag   = rst ? "R1" : "R10";
        if (busy !== m_busy) begin
            miscompares++;
            $display("FAIL %s R9 busy: got %b exp %b at cycle %0d", tag, busy, m_busy, cycles);
        end
        if (done !== m_done) begin
            miscompares++;
            $display("FAIL R8 done: got %b exp %b at cycle %0d", done, m_done, cycles);
        end
        if (mdc !== e_mdc) begin
            miscompares++;
            $display("FAIL R2 mdc: got %b exp %b at cycle %0d", mdc, e_mdc, cycles);
        end
        if (mdio_oe !== e_oe) begin
            miscompares++;
            $display("FAIL R7 R6 mdio_oe: got %b exp %b slot %0d", mdio_oe, e_oe, j);
        end
        if (e_oe && mdio_o !== e_mdo) begin
            miscompares++;
            tag = (j < 32) ? "R3" : (j < 48) ? "R4" : "R6";
            $display("FAIL %s R5 mdio_o: got %b exp %b slot %0d", tag, mdio_o, e_mdo, j);
        end
        if (rdata !== m_rdata) begin
            miscompares++;
            $display("FAIL R7 R8 rdata: got %h exp %h", rdata, m_rdata);
        end
    end

    // caller is at a falling edge; returns at the falling edge of the done cycle
    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pv, input bit poke);
        is_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd; phy_val = pv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R9: stray request with every field inverted mid-frame
            repeat (700) @(negedge clk);
            is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (done !== 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        run_txn(1'b0, 5'd0,  5'd20, 16'h0452, 16'h0000, 1'b0);  // R6 sparse word
        repeat (5) @(negedge clk);
        run_txn(1'b1, 5'd5,  5'd1,  16'hFFFF, 16'hA5C3, 1'b0);  // R7
        run_txn(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);  // R10 back-to-back
        run_txn(1'b0, 5'd10, 5'd21, 16'h5555, 16'h0000, 1'b1);  // R9 write poked
        run_txn(1'b1, 5'd17, 5'd0,  16'h1234, 16'h8001, 1'b1);  // R9 read poked
        repeat (5) @(negedge clk);
        run_txn(1'b1, 5'd0,  5'd2,  16'h0000, 16'h0000, 1'b0);  // R7 zero word
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired: got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule